// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a 64x64 cursor image over a stream of display pixels. Each pixel of the cursor carries two bits, A and B. The image sits in video memory, and each row is stored as alternating 16-bit A and B words. Software programs an origin, a pattern skip offset, a storage base, two colours and a decode style through a byte-wide register port. For every valid beam coordinate the block works out whether the beam lies inside the visible part of the cursor. If it does, the block reads the matching A/B word pair from memory and replaces the screen pixel with one of four results: the background colour, the foreground colour, the screen pixel, or its bitwise inverse.

Two decode tables are available. A desktop-style table treats code 00 as background and 01 as foreground, with 1x codes showing the screen pixel or its inverse. A windowing-system-style table treats 0x codes as transparent and 1x codes as the two colours. The horizontal and vertical positions move together. A new origin is applied only when the upper byte of the vertical origin is written, so a cursor that moves between frames is never shown at half-updated coordinates.

Top module: `hwcursor_overlay`

## Requirements
- R1: After reset the cursor is disabled, the desktop decode table is selected, origin, pattern offsets and storage base are 0, the foreground colour is 0xFF and the background colour is 0x00. `pix_o`, `pix_vld_o` and `mem_re_o` are 0.
- R2: Register writes (`cfg_we`, 4-bit `cfg_idx`, 8-bit `cfg_wdata`) use this map: 0 enable (bit 0), 1 decode style (bit 4, 1 = windowing-system table), 2 and 3 horizontal origin low byte and bits 10:8, 4 and 5 vertical origin low byte and bits 10:8, 6 and 7 storage base low byte and bits 11:8, 8 and 9 horizontal and vertical pattern offsets (bits 5:0), 10 foreground, 11 background. Bits outside these fields are ignored.
- R3: Writes to indices 2, 3 and 4 are held in staging. The displayed origin takes on both staged values, together with the new upper vertical bits, only when index 5 is written.
- R4: With origin (OX,OY) and offsets (PX,PY), a pixel at (X,Y) is covered when 0 <= X-OX < 64-PX and 0 <= Y-OY < 64-PY. It then uses bitmap column PX+(X-OX) and row PY+(Y-OY).
- R5: For column C and row R, the block reads the 32-bit word at word address base*256 + R*4 + C/16, with `mem_re_o` high, one clock after the pixel is sampled. The memory returns the data one clock later. Bits 15:0 hold the A word and bits 31:16 hold the B word, and column C uses bit 15-(C mod 16) of each.
- R6: In the desktop table, code AB=00 gives the background, 01 the foreground, 10 the screen pixel and 11 the bitwise inverse of the screen pixel.
- R7: In the windowing-system table, codes 00 and 01 give the screen pixel, 10 gives the background and 11 gives the foreground.
- R8: When the cursor is disabled or the pixel is not covered, the output equals the screen pixel, and `mem_re_o` stays low for that pixel.
- R9: The result and `pix_vld_o` appear two clock edges after the coordinate is sampled. While no valid result arrives, `pix_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 8 | Register write data |
| pix_vld_i | input | 1 | Coordinate and screen pixel valid |
| pix_x_i | input | 11 | Beam column |
| pix_y_i | input | 11 | Beam row |
| pix_i | input | 8 | Screen pixel |
| mem_re_o | output | 1 | Cursor bitmap read request |
| mem_addr_o | output | 20 | Bitmap word address (32-bit words) |
| mem_rdata_i | input | 32 | Bitmap word, one cycle after the request |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_o | output | 8 | Final pixel |

## Verification
Full raster sweeps run over a margin around the cursor, once with each decode table. The bitmap words are derived arithmetically from the address, so every pixel checks the address formation and the bit order within the word together with the code table. A second placement near the top coordinate limit, with non-zero skip offsets, separates correct window clipping from off-by-one column or row selection. A corner placement at the origin with maximum offsets and maximum base tests wraparound of the signed comparison and the truncation of the register fields. Origin writes without the commit write, and sweeps with the cursor disabled, show whether staging and pass-through keep the screen pixel untouched.

// File: rtl/hwcursor_pkg.sv
package hwcursor_pkg;

  typedef enum logic [3:0] {
    CREG_ENABLE = 4'd0,
    CREG_STYLE  = 4'd1,
    CREG_XLO    = 4'd2,
    CREG_XHI    = 4'd3,
    CREG_YLO    = 4'd4,
    CREG_YHI    = 4'd5,
    CREG_BASELO = 4'd6,
    CREG_BASEHI = 4'd7,
    CREG_SKIPX  = 4'd8,
    CREG_SKIPY  = 4'd9,
    CREG_FG     = 4'd10,
    CREG_BG     = 4'd11
  } creg_e;

  localparam int unsigned ENABLE_BIT = 0;
  localparam int unsigned STYLE_BIT  = 4;

endpackage

// File: rtl/hwcursor_regs.sv
module hwcursor_regs
  import hwcursor_pkg::*;
#(
  parameter int unsigned COORD_W = 11,
  parameter int unsigned BASE_W  = 12,
  parameter int unsigned SKIP_W  = 6,
  parameter int unsigned COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [3:0]         idx_i,
  input  logic [7:0]         wdata_i,
  output logic               enable_o,
  output logic               style_o,
  output logic [COORD_W-1:0] org_x_o,
  output logic [COORD_W-1:0] org_y_o,
  output logic [BASE_W-1:0]  base_o,
  output logic [SKIP_W-1:0]  skip_x_o,
  output logic [SKIP_W-1:0]  skip_y_o,
  output logic [COLOR_W-1:0] fg_o,
  output logic [COLOR_W-1:0] bg_o
);

  localparam int unsigned CHI_W = COORD_W - 8;
  localparam int unsigned BHI_W = BASE_W - 8;

  logic               en_q, en_d;
  logic               sty_q, sty_d;
  logic [COORD_W-1:0] stg_x_q, stg_x_d;
  logic [7:0]         stg_ylo_q, stg_ylo_d;
  logic [COORD_W-1:0] act_x_q, act_x_d;
  logic [COORD_W-1:0] act_y_q, act_y_d;
  logic [BASE_W-1:0]  base_q, base_d;
  logic [SKIP_W-1:0]  skx_q, skx_d, sky_q, sky_d;
  logic [COLOR_W-1:0] fg_q, fg_d, bg_q, bg_d;

  always_comb begin
    en_d      = en_q;
    sty_d     = sty_q;
    stg_x_d   = stg_x_q;
    stg_ylo_d = stg_ylo_q;
    act_x_d   = act_x_q;
    act_y_d   = act_y_q;
    base_d    = base_q;
    skx_d     = skx_q;
    sky_d     = sky_q;
    fg_d      = fg_q;
    bg_d      = bg_q;
    if (we_i) begin
      case (creg_e'(idx_i))
        CREG_ENABLE: en_d = wdata_i[ENABLE_BIT];
        CREG_STYLE:  sty_d = wdata_i[STYLE_BIT];
        CREG_XLO:    stg_x_d[7:0] = wdata_i;
        CREG_XHI:    stg_x_d[COORD_W-1:8] = wdata_i[CHI_W-1:0];
        CREG_YLO:    stg_ylo_d = wdata_i;
        CREG_YHI: begin
          // commit point: both axes move together
          act_x_d = stg_x_q;
          act_y_d = {wdata_i[CHI_W-1:0], stg_ylo_q};
        end
        CREG_BASELO: base_d[7:0] = wdata_i;
        CREG_BASEHI: base_d[BASE_W-1:8] = wdata_i[BHI_W-1:0];
        CREG_SKIPX:  skx_d = wdata_i[SKIP_W-1:0];
        CREG_SKIPY:  sky_d = wdata_i[SKIP_W-1:0];
        CREG_FG:     fg_d = wdata_i[COLOR_W-1:0];
        CREG_BG:     bg_d = wdata_i[COLOR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      sty_q     <= 1'b0;
      stg_x_q   <= '0;
      stg_ylo_q <= '0;
      act_x_q   <= '0;
      act_y_q   <= '0;
      base_q    <= '0;
      skx_q     <= '0;
      sky_q     <= '0;
      fg_q      <= '1;
      bg_q      <= '0;
    end else if (we_i) begin
      en_q      <= en_d;
      sty_q     <= sty_d;
      stg_x_q   <= stg_x_d;
      stg_ylo_q <= stg_ylo_d;
      act_x_q   <= act_x_d;
      act_y_q   <= act_y_d;
      base_q    <= base_d;
      skx_q     <= skx_d;
      sky_q     <= sky_d;
      fg_q      <= fg_d;
      bg_q      <= bg_d;
    end
  end

  assign enable_o = en_q;
  assign style_o  = sty_q;
  assign org_x_o  = act_x_q;
  assign org_y_o  = act_y_q;
  assign base_o   = base_q;
  assign skip_x_o = skx_q;
  assign skip_y_o = sky_q;
  assign fg_o     = fg_q;
  assign bg_o     = bg_q;

  // R3: displayed origin only moves on the commit write
  assert_commit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && idx_i == CREG_YHI) |=> ($stable(org_x_o) && $stable(org_y_o)));

endmodule

// File: rtl/hwcursor_axis.sv
module hwcursor_axis #(
  parameter int unsigned COORD_W = 11,
  parameter int unsigned CUR_DIM = 64,
  localparam int unsigned IDX_W  = $clog2(CUR_DIM)
) (
  input  logic [COORD_W-1:0] pos_i,
  input  logic [COORD_W-1:0] org_i,
  input  logic [IDX_W-1:0]   skip_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);

  logic [COORD_W:0] diff;
  logic [COORD_W:0] span;

  always_comb begin
    diff  = {1'b0, pos_i} - {1'b0, org_i};
    span  = (COORD_W+1)'(CUR_DIM) - {{(COORD_W+1-IDX_W){1'b0}}, skip_i};
    hit_o = !diff[COORD_W] && (diff < span);
    idx_o = diff[IDX_W-1:0] + skip_i;
  end

endmodule

// File: rtl/hwcursor_mux.sv
module hwcursor_mux #(
  parameter int unsigned COLOR_W = 8
) (
  input  logic               show_i,
  input  logic               style_i,
  input  logic               a_i,
  input  logic               b_i,
  input  logic [COLOR_W-1:0] pix_i,
  input  logic [COLOR_W-1:0] fg_i,
  input  logic [COLOR_W-1:0] bg_i,
  output logic [COLOR_W-1:0] pix_o
);

  always_comb begin
    pix_o = pix_i;
    if (show_i) begin
      if (style_i) begin
        case ({a_i, b_i})
          2'b10:   pix_o = bg_i;
          2'b11:   pix_o = fg_i;
          default: pix_o = pix_i;
        endcase
      end else begin
        case ({a_i, b_i})
          2'b00:   pix_o = bg_i;
          2'b01:   pix_o = fg_i;
          2'b10:   pix_o = pix_i;
          default: pix_o = ~pix_i;
        endcase
      end
    end
  end

endmodule

// File: rtl/hwcursor_overlay.sv
module hwcursor_overlay #(
  parameter int unsigned COORD_W = 11,
  parameter int unsigned COLOR_W = 8,
  parameter int unsigned BASE_W  = 12,
  parameter int unsigned CUR_DIM = 64,
  localparam int unsigned IDX_W  = $clog2(CUR_DIM),
  localparam int unsigned GRP_W  = IDX_W - 4,
  localparam int unsigned MEM_AW = BASE_W + IDX_W + GRP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_idx,
  input  logic [7:0]         cfg_wdata,
  input  logic               pix_vld_i,
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  input  logic [COLOR_W-1:0] pix_i,
  output logic               mem_re_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  input  logic [31:0]        mem_rdata_i,
  output logic               pix_vld_o,
  output logic [COLOR_W-1:0] pix_o
);

  logic               enable, style;
  logic [COORD_W-1:0] org_x, org_y;
  logic [BASE_W-1:0]  base;
  logic [IDX_W-1:0]   skip_x, skip_y;
  logic [COLOR_W-1:0] fg, bg;

  hwcursor_regs #(
    .COORD_W(COORD_W), .BASE_W(BASE_W), .SKIP_W(IDX_W), .COLOR_W(COLOR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .idx_i(cfg_idx), .wdata_i(cfg_wdata),
    .enable_o(enable), .style_o(style), .org_x_o(org_x), .org_y_o(org_y),
    .base_o(base), .skip_x_o(skip_x), .skip_y_o(skip_y), .fg_o(fg), .bg_o(bg)
  );

  // axis 0 = horizontal, axis 1 = vertical
  logic [COORD_W-1:0] ax_pos  [2];
  logic [COORD_W-1:0] ax_org  [2];
  logic [IDX_W-1:0]   ax_skip [2];
  logic               ax_hit  [2];
  logic [IDX_W-1:0]   ax_idx  [2];

  assign ax_pos[0]  = pix_x_i;
  assign ax_pos[1]  = pix_y_i;
  assign ax_org[0]  = org_x;
  assign ax_org[1]  = org_y;
  assign ax_skip[0] = skip_x;
  assign ax_skip[1] = skip_y;

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    hwcursor_axis #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM)) axis_i (
      .pos_i(ax_pos[ax]), .org_i(ax_org[ax]), .skip_i(ax_skip[ax]),
      .hit_o(ax_hit[ax]), .idx_o(ax_idx[ax])
    );

    // R4: a covered pixel never selects a column/row before the skip
    assert_idx_after_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ax_hit[ax] |-> (ax_idx[ax] >= ax_skip[ax]));
  end

  // ---------------- stage 1: locate and issue the read ----------------
  logic               show_now;
  logic               s1_vld_q, s1_show_q, s1_sty_q;
  logic [3:0]         s1_bit_q;
  logic [COLOR_W-1:0] s1_pix_q, s1_fg_q, s1_bg_q;
  logic               re_q, re_d;
  logic [MEM_AW-1:0]  addr_q, addr_d;

  always_comb begin
    show_now = enable && ax_hit[0] && ax_hit[1];
    re_d     = pix_vld_i && show_now;
    addr_d   = {base, ax_idx[1], ax_idx[0][IDX_W-1:4]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      re_q     <= 1'b0;
    end else begin
      s1_vld_q <= pix_vld_i;
      re_q     <= re_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_show_q <= 1'b0;
      s1_sty_q  <= 1'b0;
      s1_bit_q  <= '0;
      s1_pix_q  <= '0;
      s1_fg_q   <= '0;
      s1_bg_q   <= '0;
      addr_q    <= '0;
    end else if (pix_vld_i) begin
      s1_show_q <= show_now;
      s1_sty_q  <= style;
      s1_bit_q  <= ax_idx[0][3:0];
      s1_pix_q  <= pix_i;
      s1_fg_q   <= fg;
      s1_bg_q   <= bg;
      addr_q    <= addr_d;
    end
  end

  assign mem_re_o   = re_q;
  assign mem_addr_o = addr_q;

  // ---------------- stage 2: wait for memory ----------------
  logic               s2_vld_q, s2_show_q, s2_sty_q;
  logic [3:0]         s2_bit_q;
  logic [COLOR_W-1:0] s2_pix_q, s2_fg_q, s2_bg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_q <= 1'b0;
    end else begin
      s2_vld_q <= s1_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_show_q <= 1'b0;
      s2_sty_q  <= 1'b0;
      s2_bit_q  <= '0;
      s2_pix_q  <= '0;
      s2_fg_q   <= '0;
      s2_bg_q   <= '0;
    end else if (s1_vld_q) begin
      s2_show_q <= s1_show_q;
      s2_sty_q  <= s1_sty_q;
      s2_bit_q  <= s1_bit_q;
      s2_pix_q  <= s1_pix_q;
      s2_fg_q   <= s1_fg_q;
      s2_bg_q   <= s1_bg_q;
    end
  end

  // ---------------- output stage: decode ----------------
  logic               a_bit, b_bit;
  logic [COLOR_W-1:0] mux_pix;
  logic               out_vld_q;
  logic [COLOR_W-1:0] out_pix_q;

  always_comb begin
    a_bit = mem_rdata_i[{1'b0, ~s2_bit_q}];
    b_bit = mem_rdata_i[{1'b1, ~s2_bit_q}];
  end

  hwcursor_mux #(.COLOR_W(COLOR_W)) mux_i (
    .show_i(s2_show_q), .style_i(s2_sty_q), .a_i(a_bit), .b_i(b_bit),
    .pix_i(s2_pix_q), .fg_i(s2_fg_q), .bg_i(s2_bg_q), .pix_o(mux_pix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= s2_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix_q <= '0;
    end else if (s2_vld_q) begin
      out_pix_q <= mux_pix;
    end
  end

  assign pix_vld_o = out_vld_q;
  assign pix_o     = out_pix_q;

  // ---------------- checks ----------------
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R9: valid emerges a fixed two edges after the coordinate is taken
  assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (pix_vld_o == $past(pix_vld_i, 3)));

  // R6: desktop table, code 11 inverts the screen pixel
  assert_invert_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld_q && s2_show_q && !s2_sty_q && a_bit && b_bit)
      |=> ((pix_o ^ $past(s2_pix_q)) == {COLOR_W{1'b1}}));

  // R7: windowing-system table, A=0 is transparent
  assert_transparent_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld_q && s2_show_q && s2_sty_q && !a_bit) |=> (pix_o == $past(s2_pix_q)));

  // R8: uncovered or disabled pixels pass through
  assert_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld_q && !s2_show_q) |=> (pix_o == $past(s2_pix_q)));

  // R9: output holds while nothing valid arrives
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld_q |=> $stable(pix_o));

endmodule

// File: tb/hwcursor_overlay_tb_top.sv
module hwcursor_overlay_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic        pix_vld_i;
  logic [10:0] pix_x_i, pix_y_i;
  logic [7:0]  pix_i;
  logic        mem_re_o;
  logic [19:0] mem_addr_o;
  logic [31:0] mem_rdata_i;
  logic        pix_vld_o;
  logic [7:0]  pix_o;

  int n_checks = 0;
  int n_fail   = 0;

  hwcursor_overlay dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .pix_vld_i(pix_vld_i), .pix_x_i(pix_x_i), .pix_y_i(pix_y_i), .pix_i(pix_i),
    .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .pix_vld_o(pix_vld_o), .pix_o(pix_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] memf(input logic [19:0] a);
    logic [31:0] w;
    w = {12'd0, a};
    return (w * 32'h9E3779B1) ^ 32'h5A3C96E1 ^ (w << 7);
  endfunction

  function automatic logic [7:0] pixf(input int x, input int y);
    return 8'((x * 37 + y * 11)) ^ 8'h5C;
  endfunction

  // synchronous memory, one cycle read latency (R5)
  always @(posedge clk) mem_rdata_i <= memf(mem_addr_o);

  // ---- model state (R1 reset values, R2 map, R3 staging) ----
  logic        m_en, m_sty;
  logic [10:0] m_ox, m_oy, st_x;
  logic [7:0]  st_ylo;
  logic [11:0] m_base;
  logic [5:0]  m_px, m_py;
  logic [7:0]  m_fg, m_bg;

  // pipeline of expectations
  logic        e1_v, e2_v, e3_v, r1;
  logic [7:0]  e1_p, e2_p, e3_p, last_out;
  string       e1_t, e2_t, e3_t;

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
    case (idx)
      0:  m_en = d[0];
      1:  m_sty = d[4];
      2:  st_x[7:0] = d;
      3:  st_x[10:8] = d[2:0];
      4:  st_ylo = d;
      5:  begin m_ox = st_x; m_oy = {d[2:0], st_ylo}; end
      6:  m_base[7:0] = d;
      7:  m_base[11:8] = d[3:0];
      8:  m_px = d[5:0];
      9:  m_py = d[5:0];
      10: m_fg = d;
      11: m_bg = d;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_pos(input int ox, input int oy, input logic commit);
    wr(2, 8'(ox));
    wr(3, 8'hF8 | 8'((ox >> 8) & 7));
    wr(4, 8'(oy));
    if (commit) wr(5, 8'hF8 | 8'((oy >> 8) & 7));
  endtask

  // expected result for one pixel (R4..R8)
  task automatic model(input int x, input int y, input logic [7:0] p,
                       output logic [7:0] res, output logic show, output string tag);
    int rx, ry, col, row;
    logic [19:0] addr;
    logic [31:0] w;
    logic a, b;
    rx = x - int'(m_ox);
    ry = y - int'(m_oy);
    show = m_en && rx >= 0 && rx < 64 - int'(m_px) && ry >= 0 && ry < 64 - int'(m_py);
    res = p;
    tag = m_en ? "R4" : "R8";
    if (show) begin
      col  = rx + int'(m_px);
      row  = ry + int'(m_py);
      addr = 20'(int'(m_base) * 256 + row * 4 + col / 16);
      w    = memf(addr);
      a    = w[15 - (col % 16)];
      b    = w[31 - (col % 16)];
      if (m_sty) begin
        tag = "R7";
        if (a) res = b ? m_fg : m_bg;
      end else begin
        tag = "R6";
        case ({a, b})
          2'b00: res = m_bg;
          2'b01: res = m_fg;
          2'b10: res = p;
          default: res = ~p;
        endcase
      end
    end
  endtask

  task automatic step(input logic v, input int x, input int y, input string tovr);
    logic [7:0] p, res;
    logic show;
    string tag;
    // result of the drive three negedges ago (two edges of latency, R9)
    chk(pix_vld_o === e3_v, "R9", "valid", int'(pix_vld_o), int'(e3_v));
    if (e3_v) begin
      chk(pix_o === e3_p, e3_t, "pixel", int'(pix_o), int'(e3_p));
      last_out = e3_p;
    end else begin
      chk(pix_o === last_out, "R9", "hold", int'(pix_o), int'(last_out));
    end
    chk(mem_re_o === r1, "R5", "read request", int'(mem_re_o), int'(r1));
    e3_v = e2_v; e3_p = e2_p; e3_t = e2_t;
    e2_v = e1_v; e2_p = e1_p; e2_t = e1_t;
    p = pixf(x, y);
    model(x, y, p, res, show, tag);
    if (tovr != "") tag = tovr;
    e1_v = v; e1_p = res; e1_t = tag;
    r1 = v && show;
    pix_vld_i = v; pix_x_i = 11'(x); pix_y_i = 11'(y); pix_i = p;
    @(negedge clk);
  endtask

  task automatic scan(input int x0, input int x1, input int y0, input int y1,
                      input string tovr);
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) step(1'b1, x, y, tovr);
      step(1'b0, 0, 0, tovr);
    end
    for (int k = 0; k < 3; k++) step(1'b0, 0, 0, tovr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    pix_vld_i = 1'b0; pix_x_i = '0; pix_y_i = '0; pix_i = '0;
    m_en = 0; m_sty = 0; m_ox = 0; m_oy = 0; st_x = 0; st_ylo = 0;
    m_base = 0; m_px = 0; m_py = 0; m_fg = 8'hFF; m_bg = 8'h00;
    e1_v = 0; e2_v = 0; e3_v = 0; r1 = 0; e1_p = 0; e2_p = 0; e3_p = 0;
    e1_t = ""; e2_t = ""; e3_t = ""; last_out = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state at the ports
    chk(pix_o === 8'h00, "R1", "reset pixel", int'(pix_o), 0);
    chk(pix_vld_o === 1'b0, "R1", "reset valid", int'(pix_vld_o), 0);
    chk(mem_re_o === 1'b0, "R1", "reset read", int'(mem_re_o), 0);

    // disabled after reset: pass-through (R1, R8)
    scan(0, 20, 0, 3, "R1");

    // desktop table with reset colours, full sweep (R4, R5, R6)
    wr(0, 8'h01);
    wr(6, 8'h05);
    set_pos(100, 40, 1'b1);
    scan(98, 166, 38, 106, "");

    // staged origin is not applied until the commit (R3)
    set_pos(300, 200, 1'b0);
    scan(98, 120, 40, 42, "R3");
    scan(298, 310, 200, 201, "R3");
    wr(5, 8'h00 | 8'((200 >> 8) & 7));
    scan(298, 310, 200, 201, "R3");

    // windowing-system table, programmed colours, same place (R7)
    wr(1, 8'hEF);
    wr(1, 8'h10);
    wr(10, 8'h3C);
    wr(11, 8'hA5);
    set_pos(100, 40, 1'b1);
    scan(98, 166, 38, 106, "");

    // skip offsets near the coordinate limit (R4)
    wr(8, 8'hCA);
    wr(9, 8'hF2);
    wr(6, 8'h9D);
    wr(7, 8'h03);
    set_pos(2000, 2030, 1'b1);
    scan(1996, 2047, 2026, 2047, "R4");

    // corner: origin 0, maximum skip, maximum base, field masking (R2)
    wr(1, 8'h00);
    wr(8, 8'hFF);
    wr(9, 8'h7F);
    wr(6, 8'hFF);
    wr(7, 8'hFF);
    set_pos(0, 0, 1'b1);
    scan(0, 3, 0, 3, "R2");
    wr(8, 8'h00);
    wr(9, 8'h00);
    scan(0, 70, 0, 66, "R2");

    // enable bit cleared with other bits set: pass-through (R8)
    wr(0, 8'hFE);
    scan(0, 40, 0, 10, "R8");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule